// File: doc/BRIEF.md
# Register-Loaded Frame Transmitter

The block holds a small buffer of 32-bit words that a host fills through an AXI4-Lite slave port. Once the host has loaded the buffer and a frame length, it sets a start bit. The block then sends that many words, lowest index first, on an AXI4-Stream master port and marks the final word with TLAST. Start, done, idle and ready control bits report the state of a run. An auto-restart option repeats runs with no further host action.

At the end of each run the block updates a status word and raises a status-valid flag, which clears when it is read. The status word holds the word count, a running count of frames sent successfully, an out-of-range flag and the largest frame the block supports. A run with length zero sends nothing. It only refreshes the status word, so host software can discover the buffer depth. Two interrupt sources, run end and start acceptance, are latched in a toggle-on-write status register. Each source is gated by its own enable bit and by a global enable.

Top module: `regframe_tx`

## Requirements
- R1: The frame length at byte offset 0x10 reads back as written. Buffer word n is written and read at byte offset 0x40 + 4n, for n from 0 to 15.
- R2: After reset, the control register at 0x00 reads 0x0000000C (idle is bit 2, ready is bit 3), the status word at 0x80 reads 0x40000000, the status-valid flag at 0x84 reads 0, and irq_o is low.
- R3: A run with a length L from 1 to 16 sends buffer words 0 to L-1 in order, with TLAST set on the final word only. TDATA and TLAST hold steady while TVALID is high and TREADY is low.
- R4: The done bit (bit 1 at 0x00) is set on the cycle after the final stream handshake. A read of 0x00 clears it.
- R5: The start bit (bit 0 at 0x00) clears when a run is accepted, unless auto-restart (bit 7 at 0x00) is set. With auto-restart set, the start bit stays set and runs follow each other back to back.
- R6: A run with length 0 sends no words. It leaves the status word with 16 in bits 31:26, a count of 0, and the out-of-range flag clear.
- R7: A run with a length above 16 sends no words. It sets the out-of-range flag (bit 3 of the status word) and leaves the frame counter unchanged.
- R8: In the status word, bits 9:4 hold the word count of the last run, and bits 25:10 hold the number of frames sent successfully since reset. Bit 0 is high while a frame is being sent. Bits 2:1 read 0.
- R9: The status-valid flag (bit 0 at 0x84) is set when a run ends and cleared by a read of 0x84.
- R10: In the interrupt status register at 0x0c, bit 0 is set when a run ends and bit 1 is set when a start is accepted. Writing a 1 to a bit toggles it.
- R11: irq_o is high exactly when the global enable (bit 0 at 0x04) is set and some interrupt status bit is set whose enable bit at 0x08 is also set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| s_axil_awaddr_i | input | 8 | Write address (byte) |
| s_axil_awvalid_i | input | 1 | Write address valid |
| s_axil_awready_o | output | 1 | Write address ready |
| s_axil_wdata_i | input | 32 | Write data |
| s_axil_wvalid_i | input | 1 | Write data valid |
| s_axil_wready_o | output | 1 | Write data ready |
| s_axil_bresp_o | output | 2 | Write response, always OKAY |
| s_axil_bvalid_o | output | 1 | Write response valid |
| s_axil_bready_i | input | 1 | Write response ready |
| s_axil_araddr_i | input | 8 | Read address (byte) |
| s_axil_arvalid_i | input | 1 | Read address valid |
| s_axil_arready_o | output | 1 | Read address ready |
| s_axil_rdata_o | output | 32 | Read data |
| s_axil_rresp_o | output | 2 | Read response, always OKAY |
| s_axil_rvalid_o | output | 1 | Read data valid |
| s_axil_rready_i | input | 1 | Read data ready |
| m_axis_tdata_o | output | 32 | Stream data |
| m_axis_tvalid_o | output | 1 | Stream valid |
| m_axis_tready_i | input | 1 | Stream ready |
| m_axis_tlast_o | output | 1 | Final word of a frame |
| irq_o | output | 1 | Interrupt request |

## Verification
Two situations are hard to reach from the ports. The first is the running bit in the status word, which is only visible in the middle of a run. The bench holds TREADY low so that a frame stalls with its first word pending, reads the status word, and then releases the stream. The second is auto-restart, where frames follow each other with no host action. The bench sets the start and auto-restart bits together, clears auto-restart some cycles later, and then checks that the frame counter in the status word advanced by exactly the number of TLAST handshakes it saw. A length sweep from 1 to 16, with a new buffer pattern for each length and periodic backpressure on odd lengths, covers ordering and TLAST placement. The sweep also feeds the arithmetic model of the status word.

// File: rtl/regframe_pkg.sv
package regframe_pkg;
  localparam int unsigned OFF_CTRL = 'h00;
  localparam int unsigned OFF_GIE  = 'h04;
  localparam int unsigned OFF_IER  = 'h08;
  localparam int unsigned OFF_ISR  = 'h0c;
  localparam int unsigned OFF_SIZE = 'h10;
  localparam int unsigned BUF_BASE = 'h40;
  localparam int unsigned OFF_STAT = 'h80;
  localparam int unsigned OFF_SVLD = 'h84;

  typedef struct packed {
    logic [5:0]  max_words;
    logic [15:0] seq;
    logic [5:0]  count;
    logic        invalid;
    logic        too_long;
    logic        too_short;
    logic        running;
  } status_t;
endpackage

// File: rtl/regframe_seq.sv
module regframe_seq
  import regframe_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned IDX_W = $clog2(DEPTH),
  localparam int unsigned LEN_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [31:0]      size_i,
  input  logic [31:0]      word_i,
  input  logic             tready_i,
  output logic             accept_o,
  output logic             finish_o,
  output logic             busy_o,
  output logic [IDX_W-1:0] rd_idx_o,
  output logic             tvalid_o,
  output logic             tlast_o,
  output logic [31:0]      tdata_o,
  output status_t          status_o
);
  logic             sending_q, inv_q;
  logic [IDX_W-1:0] idx_q;
  logic [LEN_W-1:0] len_q;
  logic [15:0]      seq_q;
  logic [5:0]       cnt_q;
  logic [31:0]      tdata_q;
  logic             size_big, size_ok, last_beat, hs;

  assign size_big  = size_i > 32'(DEPTH);
  assign size_ok   = (size_i != '0) && !size_big;
  assign accept_o  = start_i && !sending_q;
  assign last_beat = (LEN_W'(idx_q) + LEN_W'(1)) == len_q;
  assign hs        = sending_q && tready_i;
  assign finish_o  = (accept_o && !size_ok) || (hs && last_beat);
  // next word to preload into the output register
  assign rd_idx_o  = accept_o ? '0 : idx_q + IDX_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sending_q <= 1'b0;
      idx_q     <= '0;
      len_q     <= '0;
      tdata_q   <= '0;
      seq_q     <= '0;
      cnt_q     <= '0;
      inv_q     <= 1'b0;
    end else begin
      if (accept_o && size_ok) begin
        sending_q <= 1'b1;
        idx_q     <= '0;
        len_q     <= size_i[LEN_W-1:0];
        tdata_q   <= word_i;
      end else if (hs) begin
        if (last_beat) sending_q <= 1'b0;
        else begin
          idx_q   <= idx_q + IDX_W'(1);
          tdata_q <= word_i;
        end
      end
      if (finish_o) begin
        inv_q <= accept_o && size_big;
        cnt_q <= hs ? 6'(len_q) : '0;
        if (hs) seq_q <= seq_q + 16'd1;
      end
    end
  end

  assign busy_o   = sending_q;
  assign tvalid_o = sending_q;
  assign tlast_o  = sending_q && last_beat;
  assign tdata_o  = tdata_q;

  always_comb begin
    status_o           = '0;
    status_o.max_words = 6'(DEPTH);
    status_o.seq       = seq_q;
    status_o.count     = cnt_q;
    status_o.invalid   = inv_q;
    status_o.running   = sending_q;
  end
endmodule

// File: rtl/regframe_csr.sv
module regframe_csr
  import regframe_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DEPTH  = 16,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] awaddr_i,
  input  logic              awvalid_i,
  output logic              awready_o,
  input  logic [31:0]       wdata_i,
  input  logic              wvalid_i,
  output logic              wready_o,
  output logic              bvalid_o,
  input  logic              bready_i,
  input  logic [ADDR_W-1:0] araddr_i,
  input  logic              arvalid_i,
  output logic              arready_o,
  output logic [31:0]       rdata_o,
  output logic              rvalid_o,
  input  logic              rready_i,
  input  logic              accept_i,
  input  logic              finish_i,
  input  logic              busy_i,
  input  status_t           status_i,
  input  logic [IDX_W-1:0]  buf_idx_i,
  output logic [31:0]       buf_word_o,
  output logic [31:0]       size_o,
  output logic              start_o,
  output logic              done_o,
  output logic              gie_o,
  output logic              irq_o
);
  localparam logic [ADDR_W-1:0] BUF_LO = ADDR_W'(BUF_BASE);
  localparam logic [ADDR_W-1:0] BUF_HI = ADDR_W'(BUF_BASE + 4 * DEPTH);

  logic              wr_en, rd_en, bvalid_q, rvalid_q;
  logic [31:0]       rdata_q, rd_mux;
  logic              start_q, auto_q, done_q, gie_q, svld_q;
  logic [1:0]        ier_q, isr_q;
  logic [31:0]       size_q;
  logic [ADDR_W-1:0] woff, roff;
  logic              wbuf, rbuf;
  logic [31:0]       mem [DEPTH];

  assign wr_en     = awvalid_i && wvalid_i && !bvalid_q;
  assign awready_o = wr_en;
  assign wready_o  = wr_en;
  assign rd_en     = arvalid_i && !rvalid_q;
  assign arready_o = !rvalid_q;

  assign woff = awaddr_i - BUF_LO;
  assign roff = araddr_i - BUF_LO;
  assign wbuf = (awaddr_i >= BUF_LO) && (awaddr_i < BUF_HI);
  assign rbuf = (araddr_i >= BUF_LO) && (araddr_i < BUF_HI);

  for (genvar g = 0; g < DEPTH; g++) begin : gen_word
    logic [31:0] word_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) word_q <= '0;
      else if (wr_en && wbuf && IDX_W'(woff >> 2) == IDX_W'(g)) word_q <= wdata_i;
    end
    assign mem[g] = word_q;
  end

  function automatic logic hit(input logic [ADDR_W-1:0] a, input int unsigned off);
    return a == ADDR_W'(off);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q <= 1'b0; auto_q <= 1'b0; done_q <= 1'b0; gie_q <= 1'b0;
      ier_q <= '0; isr_q <= '0; size_q <= '0; svld_q <= 1'b0;
      bvalid_q <= 1'b0; rvalid_q <= 1'b0; rdata_q <= '0;
    end else begin
      if (wr_en && hit(awaddr_i, OFF_CTRL)) begin
        start_q <= wdata_i[0];
        auto_q  <= wdata_i[7];
      end else if (accept_i && !auto_q) start_q <= 1'b0;
      if (wr_en && hit(awaddr_i, OFF_GIE))  gie_q  <= wdata_i[0];
      if (wr_en && hit(awaddr_i, OFF_IER))  ier_q  <= wdata_i[1:0];
      if (wr_en && hit(awaddr_i, OFF_SIZE)) size_q <= wdata_i;
      isr_q <= ((wr_en && hit(awaddr_i, OFF_ISR)) ? isr_q ^ wdata_i[1:0] : isr_q)
               | {accept_i, finish_i};
      if (finish_i) done_q <= 1'b1;
      else if (rd_en && hit(araddr_i, OFF_CTRL)) done_q <= 1'b0;
      if (finish_i) svld_q <= 1'b1;
      else if (rd_en && hit(araddr_i, OFF_SVLD)) svld_q <= 1'b0;
      if (wr_en) bvalid_q <= 1'b1;
      else if (bready_i) bvalid_q <= 1'b0;
      if (rd_en) begin
        rvalid_q <= 1'b1;
        rdata_q  <= rd_mux;
      end else if (rready_i) rvalid_q <= 1'b0;
    end
  end

  always_comb begin
    rd_mux = '0;
    if (hit(araddr_i, OFF_CTRL))
      rd_mux = {24'b0, auto_q, 3'b0, !busy_i, !busy_i, done_q, start_q};
    else if (hit(araddr_i, OFF_GIE))  rd_mux = {31'b0, gie_q};
    else if (hit(araddr_i, OFF_IER))  rd_mux = {30'b0, ier_q};
    else if (hit(araddr_i, OFF_ISR))  rd_mux = {30'b0, isr_q};
    else if (hit(araddr_i, OFF_SIZE)) rd_mux = size_q;
    else if (hit(araddr_i, OFF_STAT)) rd_mux = status_i;
    else if (hit(araddr_i, OFF_SVLD)) rd_mux = {31'b0, svld_q};
    else if (rbuf)                    rd_mux = mem[IDX_W'(roff >> 2)];
  end

  assign bvalid_o   = bvalid_q;
  assign rvalid_o   = rvalid_q;
  assign rdata_o    = rdata_q;
  assign buf_word_o = mem[buf_idx_i];
  assign size_o     = size_q;
  assign start_o    = start_q;
  assign done_o     = done_q;
  assign gie_o      = gie_q;
  assign irq_o      = gie_q && |(isr_q & ier_q);
endmodule

// File: rtl/regframe_tx.sv
module regframe_tx
  import regframe_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DEPTH  = 16,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] s_axil_awaddr_i,
  input  logic              s_axil_awvalid_i,
  output logic              s_axil_awready_o,
  input  logic [31:0]       s_axil_wdata_i,
  input  logic              s_axil_wvalid_i,
  output logic              s_axil_wready_o,
  output logic [1:0]        s_axil_bresp_o,
  output logic              s_axil_bvalid_o,
  input  logic              s_axil_bready_i,
  input  logic [ADDR_W-1:0] s_axil_araddr_i,
  input  logic              s_axil_arvalid_i,
  output logic              s_axil_arready_o,
  output logic [31:0]       s_axil_rdata_o,
  output logic [1:0]        s_axil_rresp_o,
  output logic              s_axil_rvalid_o,
  input  logic              s_axil_rready_i,
  output logic [31:0]       m_axis_tdata_o,
  output logic              m_axis_tvalid_o,
  input  logic              m_axis_tready_i,
  output logic              m_axis_tlast_o,
  output logic              irq_o
);
  logic             start_w, accept_w, finish_w, busy_w, done_w, gie_w;
  logic [31:0]      size_w, word_w;
  logic [IDX_W-1:0] rd_idx_w;
  status_t          status_w;

  assign s_axil_bresp_o = 2'b00;
  assign s_axil_rresp_o = 2'b00;

  regframe_csr #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_csr (
    .clk_i, .rst_ni,
    .awaddr_i(s_axil_awaddr_i), .awvalid_i(s_axil_awvalid_i), .awready_o(s_axil_awready_o),
    .wdata_i(s_axil_wdata_i), .wvalid_i(s_axil_wvalid_i), .wready_o(s_axil_wready_o),
    .bvalid_o(s_axil_bvalid_o), .bready_i(s_axil_bready_i),
    .araddr_i(s_axil_araddr_i), .arvalid_i(s_axil_arvalid_i), .arready_o(s_axil_arready_o),
    .rdata_o(s_axil_rdata_o), .rvalid_o(s_axil_rvalid_o), .rready_i(s_axil_rready_i),
    .accept_i(accept_w), .finish_i(finish_w), .busy_i(busy_w), .status_i(status_w),
    .buf_idx_i(rd_idx_w), .buf_word_o(word_w), .size_o(size_w), .start_o(start_w),
    .done_o(done_w), .gie_o(gie_w), .irq_o(irq_o)
  );

  regframe_seq #(.DEPTH(DEPTH)) u_seq (
    .clk_i, .rst_ni,
    .start_i(start_w), .size_i(size_w), .word_i(word_w), .tready_i(m_axis_tready_i),
    .accept_o(accept_w), .finish_o(finish_w), .busy_o(busy_w), .rd_idx_o(rd_idx_w),
    .tvalid_o(m_axis_tvalid_o), .tlast_o(m_axis_tlast_o), .tdata_o(m_axis_tdata_o),
    .status_o(status_w)
  );
endmodule

// File: rtl/regframe_tx_chk.sv
module regframe_tx_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        tvalid_i,
  input logic        tready_i,
  input logic        tlast_i,
  input logic [31:0] tdata_i,
  input logic        irq_i,
  input logic        gie_i,
  input logic        done_i
);
  // R3
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tvalid_i && !tready_i |=> tvalid_i && $stable(tdata_i) && $stable(tlast_i));
  // R3
  last_with_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tlast_i |-> tvalid_i);
  // R4
  done_after_last_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tvalid_i && tready_i && tlast_i |=> done_i);
  // R3
  gap_after_last_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tvalid_i && tready_i && tlast_i |=> !tvalid_i);
  // R11
  irq_gated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |-> gie_i);
endmodule

bind regframe_tx regframe_tx_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .tvalid_i(m_axis_tvalid_o), .tready_i(m_axis_tready_i), .tlast_i(m_axis_tlast_o),
  .tdata_i(m_axis_tdata_o), .irq_i(irq_o), .gie_i(gie_w), .done_i(done_w)
);

// File: tb/regframe_tx_bench.sv
module regframe_tx_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  awaddr = '0, araddr = '0;
  logic        awvalid = 1'b0, wvalid = 1'b0, arvalid = 1'b0;
  logic [31:0] wdata = '0;
  logic        awready, wready, bvalid, arready, rvalid;
  logic [1:0]  bresp, rresp;
  logic [31:0] rdata, tdata;
  logic        tvalid, tlast, irq;
  logic        tready = 1'b1;
  logic        stall_mode = 1'b0, hold_low = 1'b0;
  int          cyc = 0;
  int          n_chk = 0, n_err = 0;
  logic [31:0] cap [512];
  logic        capl [512];
  int          cap_n = 0, frames = 0;
  int          exp_seq = 0;

  always #10 clk = ~clk;

  regframe_tx u_regframe_tx (
    .clk_i(clk), .rst_ni(rst_n),
    .s_axil_awaddr_i(awaddr), .s_axil_awvalid_i(awvalid), .s_axil_awready_o(awready),
    .s_axil_wdata_i(wdata), .s_axil_wvalid_i(wvalid), .s_axil_wready_o(wready),
    .s_axil_bresp_o(bresp), .s_axil_bvalid_o(bvalid), .s_axil_bready_i(1'b1),
    .s_axil_araddr_i(araddr), .s_axil_arvalid_i(arvalid), .s_axil_arready_o(arready),
    .s_axil_rdata_o(rdata), .s_axil_rresp_o(rresp), .s_axil_rvalid_o(rvalid),
    .s_axil_rready_i(1'b1),
    .m_axis_tdata_o(tdata), .m_axis_tvalid_o(tvalid), .m_axis_tready_i(tready),
    .m_axis_tlast_o(tlast), .irq_o(irq)
  );

  always @(negedge clk) begin
    cyc++;
    tready = hold_low ? 1'b0 : (stall_mode ? (cyc % 3 != 0) : 1'b1);
  end

  always @(negedge clk) begin
    #5;
    if (rst_n && tvalid && tready) begin
      cap[cap_n % 512]  = tdata;
      capl[cap_n % 512] = tlast;
      cap_n++;
      if (tlast) frames++;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    awaddr = a; wdata = d; awvalid = 1'b1; wvalid = 1'b1;
    #1;
    while (!awready) begin @(negedge clk); #1; end
    @(negedge clk);
    awvalid = 1'b0; wvalid = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    araddr = a; arvalid = 1'b1;
    #1;
    while (!arready) begin @(negedge clk); #1; end
    @(negedge clk);
    arvalid = 1'b0;
    d = rdata;
  endtask

  task automatic wait_end();
    logic [31:0] v;
    for (int i = 0; i < 300; i++) begin
      rd(8'h84, v);
      if (v[0]) return;
    end
    check("R9 run end", 32'd0, 32'd1);
  endtask

  function automatic logic [31:0] pat(input int p, input int k);
    return (32'(p) << 24) | (32'(k) << 16) | 32'(p * 37 + k * 11 + 5);
  endfunction

  function automatic logic [31:0] stat(input int seq, input int cnt, input int inv);
    return (32'd16 << 26) | (32'(seq) << 10) | (32'(cnt) << 4) | (32'(inv) << 3);
  endfunction

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [31:0] v;
    int base;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R2 reset state
    rd(8'h00, v); check("R2 ctrl", v, 32'h0000000C);
    rd(8'h84, v); check("R2 svld", v, 32'h0);
    rd(8'h80, v); check("R2 status", v, 32'h40000000);
    check("R2 irq", 32'(irq), 32'h0);

    // R1 register and buffer access
    wr(8'h10, 32'h0000_0005); rd(8'h10, v); check("R1 size", v, 32'h5);
    for (int k = 0; k < 16; k++) wr(8'(8'h40 + 4 * k), pat(99, k));
    rd(8'h4c, v); check("R1 buf3", v, pat(99, 3));
    rd(8'h7c, v); check("R1 buf15", v, pat(99, 15));

    // R6 capability run
    base = cap_n;
    wr(8'h10, 32'h0); wr(8'h00, 32'h1);
    wait_end();
    check("R6 no words", 32'(cap_n - base), 32'h0);
    rd(8'h80, v); check("R6 status", v, stat(0, 0, 0));
    rd(8'h84, v); check("R9 cleared", v, 32'h0);
    rd(8'h00, v); check("R4 R5 ctrl done", v, 32'h0000000E);
    rd(8'h00, v); check("R4 done cleared", v, 32'h0000000C);

    // R3 R8 sweep of lengths
    for (int sz = 1; sz <= 16; sz++) begin
      for (int k = 0; k < 16; k++) wr(8'(8'h40 + 4 * k), pat(sz, k));
      stall_mode = sz[0];
      base = cap_n;
      wr(8'h10, 32'(sz)); wr(8'h00, 32'h1);
      wait_end();
      stall_mode = 1'b0;
      exp_seq++;
      check("R3 count", 32'(cap_n - base), 32'(sz));
      for (int k = 0; k < sz; k++) begin
        check("R3 word", cap[(base + k) % 512], pat(sz, k));
        check("R3 tlast", 32'(capl[(base + k) % 512]), 32'(k == sz - 1));
      end
      rd(8'h80, v); check("R8 status", v, stat(exp_seq, sz, 0));
    end

    // R8 running bit while stalled
    hold_low = 1'b1;
    base = cap_n;
    wr(8'h10, 32'd4); wr(8'h00, 32'h1);
    repeat (3) @(negedge clk);
    rd(8'h80, v); check("R8 running", 32'(v[0]), 32'h1);
    check("R3 stalled valid", 32'(tvalid), 32'h1);
    hold_low = 1'b0;
    wait_end();
    exp_seq++;
    check("R3 after stall", 32'(cap_n - base), 32'd4);
    rd(8'h80, v); check("R8 status after stall", v, stat(exp_seq, 4, 0));

    // R7 out-of-range lengths
    for (int j = 0; j < 3; j++) begin
      logic [31:0] bad;
      bad = (j == 0) ? 32'd17 : (j == 1) ? 32'd32 : 32'hFFFF_FFFF;
      base = cap_n;
      wr(8'h10, bad); wr(8'h00, 32'h1);
      wait_end();
      check("R7 no words", 32'(cap_n - base), 32'h0);
      rd(8'h80, v); check("R7 status", v, stat(exp_seq, 0, 1));
    end

    // R10 R11 interrupts
    rd(8'h0c, v); check("R10 isr set", v, 32'h3);
    check("R11 no gie", 32'(irq), 32'h0);
    wr(8'h0c, 32'h3); rd(8'h0c, v); check("R10 toggle clear", v, 32'h0);
    wr(8'h08, 32'h1); wr(8'h04, 32'h1);
    check("R11 isr empty", 32'(irq), 32'h0);
    wr(8'h10, 32'd2); wr(8'h00, 32'h1);
    wait_end();
    exp_seq++;
    check("R11 irq on", 32'(irq), 32'h1);
    wr(8'h08, 32'h2); check("R11 ready chan", 32'(irq), 32'h1);
    wr(8'h08, 32'h0); check("R11 ier off", 32'(irq), 32'h0);
    wr(8'h08, 32'h1); check("R11 ier on", 32'(irq), 32'h1);
    wr(8'h0c, 32'h1); check("R11 toggled off", 32'(irq), 32'h0);
    rd(8'h0c, v); check("R10 isr bit0 toggled", v, 32'h2);
    wr(8'h0c, 32'h1); check("R11 toggled on", 32'(irq), 32'h1);
    wr(8'h04, 32'h0); check("R11 gie off", 32'(irq), 32'h0);

    // R5 auto-restart
    base = cap_n;
    frames = 0;
    wr(8'h10, 32'd3); wr(8'h00, 32'h81);
    repeat (40) @(negedge clk);
    rd(8'h00, v); check("R5 start held", v & 32'h81, 32'h81);
    wr(8'h00, 32'h0);
    repeat (20) @(negedge clk);
    rd(8'h84, v);
    check("R5 several frames", 32'(frames >= 5), 32'h1);
    check("R5 whole frames", 32'(cap_n - base), 32'(frames * 3));
    for (int k = 0; k < frames * 3 && k < 300; k++)
      check("R5 word", cap[(base + k) % 512], pat(16, k % 3));
    exp_seq += frames;
    rd(8'h80, v); check("R5 R8 seq", v, stat(exp_seq, 3, 0));
    rd(8'h00, v); check("R5 start cleared", v & 32'h81, 32'h0);

    summary();
  end
endmodule